// File: doc/BRIEF.md
# Nine-Step Segmented Karatsuba Multiplier over GF(2)

This block multiplies two binary polynomials of 4n bits each and returns their carry-less product of 8n bits. Each operand is cut into four n-bit segments. A single n-by-n carry-less multiplier is reused over nine consecutive clocks. On each clock a selector feeds it one segment pair, or an XOR of segment pairs, in a fixed Karatsuba order. The resulting (2n-1)-bit partial product is split into a low half and a high half. Each half is XORed into a chosen set of eight n-bit result segments.

A caller pulses `start` while the block is idle, with both operands on the inputs. The block raises `busy` for nine clocks. It then pulses `done` for one clock, and the product stays on the output until the next accepted start. Shorter operands are zero-extended at the top by the caller. For example, 233-bit field elements use n = 59, and the meaningful part of the result is 465 bits.

Top module: `karatsuba4_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is 0 latches `op_a` and `op_b` and sets `busy` to 1 from the next cycle.
- R3: After an accepted start, `busy` stays high for exactly 9 cycles. `done` is then high for exactly one cycle, the cycle in which `busy` first reads 0.
- R4: While `done` is high, `product` equals the carry-less product of the latched operands. Bit i of an operand is the coefficient of x^i, and bit i of `product` is the coefficient of x^i.
- R5: A `start` sampled while `busy` is 1 is ignored. The running result is not disturbed, and the product still matches the operands latched at the accepted start.
- R6: While `busy` is 0 and no start is sampled, `product` holds its value.
- R7: A start presented in the cycle where `done` is high is accepted, giving back-to-back operations with no idle cycle between them.
- R8: Corner operands give the correct product: zero, all ones, only the top segment non-zero, and only the top bit set.
- R9: The most significant bit of `product` (bit 8n-1) is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| op_a | input | 4*SEG_W | First polynomial operand |
| op_b | input | 4*SEG_W | Second polynomial operand |
| busy | output | 1 | High during the nine accumulation steps |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 8*SEG_W | Carry-less product, held until the next start |

## Verification
The bench builds the block with SEG_W = 8, so operands are 32 bits wide and the product is 64 bits. At this width every segment product is small. Random operands therefore quickly exercise all nine selection patterns and every XOR target of the low and high halves. A start ignored mid-operation and back-to-back starts in the `done` cycle can also be placed on exact cycles. Corner operands bring in the case where only the top segment feeds the four partial products that involve it, and the case where only the single top bit is set.

// File: rtl/karatsuba4_mul.sv
module karatsuba4_mul #(
  parameter int SEG_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [4*SEG_W-1:0]   op_a,
  input  logic [4*SEG_W-1:0]   op_b,
  output logic                 busy,
  output logic                 done,
  output logic [8*SEG_W-1:0]   product
);
  localparam int OP_W  = 4 * SEG_W;
  localparam int PR_W  = 8 * SEG_W;
  localparam int PP_W  = 2 * SEG_W;
  localparam int NSTEP = 9;
  localparam logic [3:0] LAST = 4'(NSTEP - 1);

  logic [OP_W-1:0] a_q, b_q;
  logic [PR_W-1:0] acc_q, acc_d;
  logic [3:0]      step_q;
  logic            busy_q, done_q;
  logic [3:0]      pick;
  logic [6:0]      wt;
  logic [SEG_W-1:0] sx, sy;
  logic [PP_W-1:0]  pp;

  // which of the four segments are XORed into the multiplier inputs
  function automatic logic [3:0] seg_pick(input logic [3:0] s);
    case (s)
      4'd0: seg_pick = 4'b0001;
      4'd1: seg_pick = 4'b0010;
      4'd2: seg_pick = 4'b0100;
      4'd3: seg_pick = 4'b1000;
      4'd4: seg_pick = 4'b0011;
      4'd5: seg_pick = 4'b0101;
      4'd6: seg_pick = 4'b1010;
      4'd7: seg_pick = 4'b1100;
      4'd8: seg_pick = 4'b1111;
      default: seg_pick = 4'b0000;
    endcase
  endfunction

  // weights x^(k*n) at which the partial product is added
  function automatic logic [6:0] weight_set(input logic [3:0] s);
    case (s)
      4'd0: weight_set = 7'b000_1111;
      4'd1: weight_set = 7'b001_1110;
      4'd2: weight_set = 7'b011_1100;
      4'd3: weight_set = 7'b111_1000;
      4'd4: weight_set = 7'b000_1010;
      4'd5: weight_set = 7'b000_1100;
      4'd6: weight_set = 7'b001_1000;
      4'd7: weight_set = 7'b010_1000;
      4'd8: weight_set = 7'b000_1000;
      default: weight_set = 7'b000_0000;
    endcase
  endfunction

  assign pick = seg_pick(step_q);
  assign wt   = weight_set(step_q);

  always_comb begin
    sx = '0;
    sy = '0;
    for (int i = 0; i < 4; i++) begin
      if (pick[i]) begin
        sx = sx ^ a_q[i*SEG_W +: SEG_W];
        sy = sy ^ b_q[i*SEG_W +: SEG_W];
      end
    end
  end

  always_comb begin
    pp = '0;
    for (int i = 0; i < SEG_W; i++) begin
      if (sy[i]) pp = pp ^ ({{SEG_W{1'b0}}, sx} << i);
    end
  end

  always_comb begin
    acc_d = acc_q;
    for (int k = 0; k < 7; k++) begin
      if (wt[k]) begin
        acc_d[k*SEG_W +: SEG_W]     = acc_d[k*SEG_W +: SEG_W] ^ pp[SEG_W-1:0];
        acc_d[(k+1)*SEG_W +: SEG_W] = acc_d[(k+1)*SEG_W +: SEG_W] ^ pp[PP_W-1:SEG_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        a_q    <= op_a;
        b_q    <= op_b;
        acc_q  <= '0;
        step_q <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc_q <= acc_d;
        if (step_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          step_q <= '0;
        end else begin
          step_q <= step_q + 4'd1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign product = acc_q;
endmodule

// File: rtl/karatsuba4_mul_chk.sv
module karatsuba4_mul_chk #(
  parameter int SEG_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [8*SEG_W-1:0] product
);
  logic [3:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 4'd1;
    else           busy_cnt <= '0;
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R3
  AST_NINE_STEPS: assert property (@(posedge clk) disable iff (!rst_n) done |-> (busy_cnt == 4'd9)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(product)); // R6
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !product[8*SEG_W-1]); // R9
endmodule

bind karatsuba4_mul karatsuba4_mul_chk #(.SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .product(product)
);

// File: tb/karatsuba4_mul_bench.sv
module karatsuba4_mul_bench;
  localparam int SEG_W = 8;
  localparam int OP_W  = 4 * SEG_W;
  localparam int PR_W  = 8 * SEG_W;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [OP_W-1:0] op_a = '0, op_b = '0;
  logic busy, done;
  logic [PR_W-1:0] product;

  int n_tests = 0;
  int n_fail  = 0;
  int busy_run = 0;
  logic [PR_W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  karatsuba4_mul #(.SEG_W(SEG_W)) u_karatsuba4_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [PR_W-1:0] ref_mul(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    logic [PR_W-1:0] r = '0;
    for (int i = 0; i < OP_W; i++)
      if (b[i]) r = r ^ ({{OP_W{1'b0}}, a} << i);
    return r;
  endfunction

  function automatic logic [OP_W-1:0] rnd_op();
    logic [OP_W-1:0] v = '0;
    for (int i = 0; i < OP_W; i += 32) v = (v << 32) | OP_W'($urandom);
    return v;
  endfunction

  task automatic check(input string req, input logic [PR_W-1:0] act, input logic [PR_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: waits for idle, presents start for one cycle, pushes the expected product
  task automatic launch(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    while (busy) @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    exp_q.push_back(ref_mul(a, b));
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", PR_W'(busy), PR_W'(1));
  endtask

  // monitor: counts busy cycles and scores each completed product
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_run++;
      if (done) begin
        check("R3 busy length", PR_W'(busy_run), PR_W'(9));
        check("R3 busy low at done", PR_W'(busy), PR_W'(0));
        if (exp_q.size() == 0) check("R4 unexpected done", PR_W'(1), PR_W'(0));
        else check("R4 product", product, exp_q.pop_front());
        busy_run = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [PR_W-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 busy", PR_W'(busy), '0);
    check("R1 done", PR_W'(done), '0);
    check("R1 product", product, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 corner operands
    launch('0, rnd_op());
    launch({OP_W{1'b1}}, {OP_W{1'b1}});
    launch({{SEG_W{1'b1}}, {(3*SEG_W){1'b0}}}, {{SEG_W{1'b1}}, {(3*SEG_W){1'b0}}});
    launch({1'b1, {(OP_W-1){1'b0}}}, {1'b1, {(OP_W-1){1'b0}}});
    launch({OP_W{1'b1}}, OP_W'(1));

    // R4 random operands, issued back to back (R7)
    for (int i = 0; i < 40; i++) launch(rnd_op(), rnd_op());

    // R7 explicit: start in the done cycle is taken
    while (!done) @(negedge clk);
    launch(rnd_op(), rnd_op());

    // R5 start while busy is ignored
    while (busy) @(negedge clk);
    launch(32'h1234_5678, 32'h9abc_def0);
    repeat (3) @(negedge clk);
    op_a = rnd_op(); op_b = rnd_op(); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);

    // R6 product held while idle
    held = product;
    repeat (6) @(negedge clk);
    check("R6 product held", product, held);
    check("R5 queue drained", PR_W'(exp_q.size()), '0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule